// File: doc/BRIEF.md
# Selector-Addressed Configuration Data Port

This block lets boot firmware read a small table of configuration items one slice at a time. A 16-bit selector write picks an item and rewinds the byte cursor to zero. Every data read then returns the next bytes of that item and moves the cursor forward. The item bytes and the per-item lengths sit in an internal byte store. A valid/ready preload stream fills that store before firmware starts reading.

Firmware reaches the block through one of two request ports. The split port has a control register, where the selector is written, and a data register, whose width is set by a parameter. The combined port is a narrow port where the access width decides what an access does. Both ports follow the valid/ready rule. A request is taken at a rising edge where valid and ready are both high. A response pulse, with an error flag and read data, follows exactly one cycle later. The split port is always ready. The combined port deasserts ready in any cycle where the split port has a request. The preload stream deasserts ready in any cycle where either request port has a request, so a preload beat waits for as long as bus traffic continues.

Top module: `cfgport_top`

## Requirements
- R1: After reset the current item is key 0 (table 0, index 0) at offset 0, and no response is pending.
- R2: Every selector write clears the byte offset to zero, whether or not the selected key is in range.
- R3: Key bits 13:0 form the index. An index at or above ENTRY_LIMIT (FILE_FIRST + FILE_SLOTS) makes the item invalid, and an invalid item reads as all zeros. ENTRY_LIMIT-1 is still valid.
- R4: Key bit 15 selects the second item table. Bit 14 is ignored.
- R5: An N-byte read places the item bytes in stream order, with the earliest byte in the most significant of the N returned bytes. The result is right-aligned in the read data, and the offset advances by the number of bytes taken.
- R6: When fewer than N bytes remain, the missing low bytes read as zero and the offset stops at the item length.
- R7: A read of an invalid item, or a read at or past the item length, returns zero and leaves the offset unchanged.
- R8: Accepted data writes, on either port, leave the item contents and the offset unchanged.
- R9: On the combined port, size 1 is a 1-byte data read (we=0) or an ignored data write (we=1), and size 2 with we=1 writes the selector from wdata[15:0]. Any other request returns an error with zero data and has no effect.
- R10: On the split port, register 0 (control) accepts only writes of size 2. Register 1 (data) accepts only addr 0 with size 1..DATA_BYTES. A rejected request returns an error with zero data and has no effect. The split port answers every request one cycle later.
- R11: Preload beats are ignored when the index is at or above ENTRY_LIMIT. A byte beat (kind 0) is also ignored when its offset is at or above ITEM_BYTES. A length beat (kind 1) stores min(field, ITEM_BYTES). pl_ready is low while either bus port has a request.
- R12: When both request ports are valid in the same cycle, only the split request is taken, and the combined port produces no response for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_valid | input | 1 | Preload beat valid |
| pl_ready | output | 1 | Preload beat accepted at this edge |
| pl_kind | input | 1 | 0 = data byte, 1 = item length |
| pl_table | input | 1 | Target table |
| pl_index | input | 14 | Target item index |
| pl_field | input | 32 | Byte offset (kind 0) or length (kind 1) |
| pl_byte | input | 8 | Data byte for kind 0 |
| sp_valid | input | 1 | Split-port request valid |
| sp_ready | output | 1 | Split-port ready (always 1) |
| sp_reg | input | 1 | 0 = control register, 1 = data register |
| sp_we | input | 1 | Write when 1 |
| sp_addr | input | 3 | Byte address within the register |
| sp_size | input | 4 | Access size in bytes |
| sp_wdata | input | 16 | Write data (selector for control writes) |
| sp_rvalid | output | 1 | Split-port response pulse |
| sp_rerr | output | 1 | Split-port request rejected |
| sp_rdata | output | 8*DATA_BYTES | Split-port read data, right-aligned |
| cb_valid | input | 1 | Combined-port request valid |
| cb_ready | output | 1 | Combined-port ready |
| cb_we | input | 1 | Write when 1 |
| cb_size | input | 4 | Access size in bytes |
| cb_wdata | input | 16 | Write data (selector for size-2 writes) |
| cb_rvalid | output | 1 | Combined-port response pulse |
| cb_rerr | output | 1 | Combined-port request rejected |
| cb_rdata | output | 8 | Combined-port read byte |

## Verification
The bound checker watches on every cycle that each request is answered one cycle later and that rejected requests return zero data. It also watches that the combined port yields to the split port, that a selector write always leaves the offset at zero, and that the offset never passes the item storage size. The byte packing, the zero padding at the end of an item, the table and limit decoding, the length clamp and the absence of effect from data writes depend on item contents. Only the bench's scenarios show those, by comparing each response against a behavioural model of the item tables and cursor.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int KEY_W     = 16;
  localparam int IDX_W     = 14;
  localparam int TBL_BIT   = 15;
  localparam int OFF_W     = 32;
  localparam int MAX_BYTES = 8;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_SELECT,
    REQ_READ,
    REQ_DROP_WRITE
  } req_kind_e;
endpackage

// File: rtl/cfgport_store.sv
module cfgport_store #(
  parameter int ENTRY_LIMIT = 8,
  parameter int ITEM_BYTES  = 16,
  parameter int DATA_BYTES  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pl_fire,
  input  logic                              pl_kind,
  input  logic                              pl_table,
  input  logic [cfgport_pkg::IDX_W-1:0]     pl_index,
  input  logic [cfgport_pkg::OFF_W-1:0]     pl_field,
  input  logic [7:0]                        pl_byte,
  input  logic                              rd_table,
  input  logic [$clog2(ENTRY_LIMIT)-1:0]    rd_slot,
  input  logic [cfgport_pkg::OFF_W-1:0]     rd_off,
  output logic [cfgport_pkg::OFF_W-1:0]     rd_len,
  output logic [8*DATA_BYTES-1:0]           rd_win
);
  import cfgport_pkg::*;

  localparam int NITEMS = 2 * ENTRY_LIMIT;
  localparam int NBYTES = NITEMS * ITEM_BYTES;
  localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(ENTRY_LIMIT);
  localparam logic [OFF_W-1:0] ITEM_SZ   = OFF_W'(ITEM_BYTES);

  logic [7:0]       mem     [NBYTES];
  logic [OFF_W-1:0] len_tab [NITEMS];

  logic pl_in_range;
  int   pl_item;
  int   rd_item;

  always_comb begin
    pl_in_range = pl_index < LIMIT_IDX;
    pl_item     = pl_in_range ? (int'(pl_table) * ENTRY_LIMIT + int'(pl_index)) : 0;
    rd_item     = int'(rd_table) * ENTRY_LIMIT + int'(rd_slot);
  end

  // byte array: no reset, lengths gate every read
  always_ff @(posedge clk) begin
    if (pl_fire && !pl_kind && pl_in_range && (pl_field < ITEM_SZ))
      mem[pl_item * ITEM_BYTES + int'(pl_field)] <= pl_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NITEMS; i++) len_tab[i] <= '0;
    end else if (pl_fire && pl_kind && pl_in_range) begin
      len_tab[pl_item] <= (pl_field > ITEM_SZ) ? ITEM_SZ : pl_field;
    end
  end

  assign rd_len = len_tab[rd_item];

  generate
    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_win
      logic [OFF_W-1:0] pos;
      assign pos = rd_off + OFF_W'(k);
      always_comb begin
        if (pos < ITEM_SZ) rd_win[8*k +: 8] = mem[rd_item * ITEM_BYTES + int'(pos)];
        else               rd_win[8*k +: 8] = 8'h00;
      end
    end
  endgenerate
endmodule

// File: rtl/cfgport_cursor.sv
module cfgport_cursor #(
  parameter int ENTRY_LIMIT = 8,
  parameter int DATA_BYTES  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sel_fire,
  input  logic [cfgport_pkg::KEY_W-1:0]     sel_key,
  input  logic                              rd_fire,
  input  logic [3:0]                        rd_n,
  input  logic [cfgport_pkg::OFF_W-1:0]     item_len,
  input  logic [8*DATA_BYTES-1:0]           item_win,
  output logic                              cur_valid,
  output logic                              cur_table,
  output logic [$clog2(ENTRY_LIMIT)-1:0]    cur_slot,
  output logic [cfgport_pkg::OFF_W-1:0]     cur_off,
  output logic [8*DATA_BYTES-1:0]           rd_data
);
  import cfgport_pkg::*;

  localparam int SLOT_W = $clog2(ENTRY_LIMIT);
  localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(ENTRY_LIMIT);

  logic [IDX_W-1:0] key_idx;
  logic             key_ok;
  logic [OFF_W-1:0] remain;
  logic [OFF_W-1:0] take;
  logic [OFF_W-1:0] want;

  assign key_idx = sel_key[IDX_W-1:0];
  assign key_ok  = key_idx < LIMIT_IDX;
  assign want    = OFF_W'(rd_n);

  always_comb begin
    remain = (cur_valid && (cur_off < item_len)) ? (item_len - cur_off) : '0;
    take   = (remain < want) ? remain : want;
  end

  // earliest stream byte lands in the top byte of the N-byte result
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (OFF_W'(k) < take)
        rd_data[8*(int'(rd_n) - 1 - k) +: 8] = item_win[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_valid <= 1'b1;
      cur_table <= 1'b0;
      cur_slot  <= '0;
      cur_off   <= '0;
    end else if (sel_fire) begin
      cur_off   <= '0;
      cur_valid <= key_ok;
      cur_table <= key_ok ? sel_key[TBL_BIT] : 1'b0;
      cur_slot  <= key_ok ? key_idx[SLOT_W-1:0] : '0;
    end else if (rd_fire) begin
      cur_off   <= cur_off + take;
    end
  end
endmodule

// File: rtl/cfgport_busdec.sv
module cfgport_busdec #(
  parameter int DATA_BYTES = 4
) (
  input  logic                          sp_valid,
  input  logic                          sp_reg,
  input  logic                          sp_we,
  input  logic [2:0]                    sp_addr,
  input  logic [3:0]                    sp_size,
  input  logic [cfgport_pkg::KEY_W-1:0] sp_wdata,
  input  logic                          cb_valid,
  input  logic                          cb_we,
  input  logic [3:0]                    cb_size,
  input  logic [cfgport_pkg::KEY_W-1:0] cb_wdata,
  output logic                          cb_ready,
  output logic                          sp_fire,
  output logic                          sp_bad,
  output logic                          sp_is_read,
  output logic                          cb_fire,
  output logic                          cb_bad,
  output logic                          cb_is_read,
  output logic                          sel_fire,
  output logic [cfgport_pkg::KEY_W-1:0] sel_key,
  output logic                          rd_fire,
  output logic [3:0]                    rd_n
);
  import cfgport_pkg::*;

  localparam logic [3:0] DB4 = 4'(DATA_BYTES);

  req_kind_e sp_kind;
  req_kind_e cb_kind;

  always_comb begin
    sp_kind = REQ_NONE;
    if (!sp_reg) begin
      if (sp_we && sp_size == 4'd2) sp_kind = REQ_SELECT;
    end else if (sp_addr == 3'd0 && sp_size != 4'd0 && sp_size <= DB4) begin
      sp_kind = sp_we ? REQ_DROP_WRITE : REQ_READ;
    end
  end

  always_comb begin
    cb_kind = REQ_NONE;
    if (cb_size == 4'd1)            cb_kind = cb_we ? REQ_DROP_WRITE : REQ_READ;
    else if (cb_size == 4'd2 && cb_we) cb_kind = REQ_SELECT;
  end

  assign cb_ready   = !sp_valid;
  assign sp_fire    = sp_valid;
  assign cb_fire    = cb_valid && cb_ready;
  assign sp_bad     = sp_kind == REQ_NONE;
  assign cb_bad     = cb_kind == REQ_NONE;
  assign sp_is_read = sp_kind == REQ_READ;
  assign cb_is_read = cb_kind == REQ_READ;

  always_comb begin
    sel_fire = 1'b0;
    sel_key  = '0;
    rd_fire  = 1'b0;
    rd_n     = 4'd1;
    if (sp_fire) begin
      sel_fire = sp_kind == REQ_SELECT;
      sel_key  = sp_wdata;
      rd_fire  = sp_kind == REQ_READ;
      rd_n     = sp_size;
    end else if (cb_fire) begin
      sel_fire = cb_kind == REQ_SELECT;
      sel_key  = cb_wdata;
      rd_fire  = cb_kind == REQ_READ;
    end
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top #(
  parameter int DATA_BYTES  = 4,
  parameter int FILE_FIRST  = 4,
  parameter int FILE_SLOTS  = 4,
  parameter int ITEM_BYTES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pl_valid,
  output logic                    pl_ready,
  input  logic                    pl_kind,
  input  logic                    pl_table,
  input  logic [13:0]             pl_index,
  input  logic [31:0]             pl_field,
  input  logic [7:0]              pl_byte,
  input  logic                    sp_valid,
  output logic                    sp_ready,
  input  logic                    sp_reg,
  input  logic                    sp_we,
  input  logic [2:0]              sp_addr,
  input  logic [3:0]              sp_size,
  input  logic [15:0]             sp_wdata,
  output logic                    sp_rvalid,
  output logic                    sp_rerr,
  output logic [8*DATA_BYTES-1:0] sp_rdata,
  input  logic                    cb_valid,
  output logic                    cb_ready,
  input  logic                    cb_we,
  input  logic [3:0]              cb_size,
  input  logic [15:0]             cb_wdata,
  output logic                    cb_rvalid,
  output logic                    cb_rerr,
  output logic [7:0]              cb_rdata
);
  import cfgport_pkg::*;

  localparam int ENTRY_LIMIT = FILE_FIRST + FILE_SLOTS;
  localparam int SLOT_W      = $clog2(ENTRY_LIMIT);

  logic                    sp_fire, sp_bad, sp_is_read;
  logic                    cb_fire, cb_bad, cb_is_read;
  logic                    sel_fire, rd_fire;
  logic [KEY_W-1:0]        sel_key;
  logic [3:0]              rd_n;
  logic                    cur_valid, cur_table;
  logic [SLOT_W-1:0]       cur_slot;
  logic [OFF_W-1:0]        cur_off, item_len;
  logic [8*DATA_BYTES-1:0] item_win, rd_data;
  logic                    pl_fire;

  assign sp_ready = 1'b1;
  assign pl_ready = !(sp_valid || cb_valid);
  assign pl_fire  = pl_valid && pl_ready;

  cfgport_busdec #(.DATA_BYTES(DATA_BYTES)) dec_i (
    .sp_valid(sp_valid), .sp_reg(sp_reg), .sp_we(sp_we), .sp_addr(sp_addr),
    .sp_size(sp_size), .sp_wdata(sp_wdata),
    .cb_valid(cb_valid), .cb_we(cb_we), .cb_size(cb_size), .cb_wdata(cb_wdata),
    .cb_ready(cb_ready),
    .sp_fire(sp_fire), .sp_bad(sp_bad), .sp_is_read(sp_is_read),
    .cb_fire(cb_fire), .cb_bad(cb_bad), .cb_is_read(cb_is_read),
    .sel_fire(sel_fire), .sel_key(sel_key), .rd_fire(rd_fire), .rd_n(rd_n)
  );

  cfgport_cursor #(.ENTRY_LIMIT(ENTRY_LIMIT), .DATA_BYTES(DATA_BYTES)) cur_i (
    .clk(clk), .rst_n(rst_n),
    .sel_fire(sel_fire), .sel_key(sel_key), .rd_fire(rd_fire), .rd_n(rd_n),
    .item_len(item_len), .item_win(item_win),
    .cur_valid(cur_valid), .cur_table(cur_table), .cur_slot(cur_slot),
    .cur_off(cur_off), .rd_data(rd_data)
  );

  cfgport_store #(.ENTRY_LIMIT(ENTRY_LIMIT), .ITEM_BYTES(ITEM_BYTES),
                  .DATA_BYTES(DATA_BYTES)) store_i (
    .clk(clk), .rst_n(rst_n),
    .pl_fire(pl_fire), .pl_kind(pl_kind), .pl_table(pl_table),
    .pl_index(pl_index), .pl_field(pl_field), .pl_byte(pl_byte),
    .rd_table(cur_table), .rd_slot(cur_slot), .rd_off(cur_off),
    .rd_len(item_len), .rd_win(item_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_rvalid <= 1'b0;
      sp_rerr   <= 1'b0;
      sp_rdata  <= '0;
      cb_rvalid <= 1'b0;
      cb_rerr   <= 1'b0;
      cb_rdata  <= '0;
    end else begin
      sp_rvalid <= sp_fire;
      sp_rerr   <= sp_fire && sp_bad;
      sp_rdata  <= (sp_fire && sp_is_read) ? rd_data : '0;
      cb_rvalid <= cb_fire;
      cb_rerr   <= cb_fire && cb_bad;
      cb_rdata  <= (cb_fire && cb_is_read) ? rd_data[7:0] : 8'h00;
    end
  end
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int DATA_BYTES = 4,
  parameter int ITEM_BYTES = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sp_valid,
  input logic                    cb_valid,
  input logic                    cb_ready,
  input logic                    sp_rvalid,
  input logic                    sp_rerr,
  input logic [8*DATA_BYTES-1:0] sp_rdata,
  input logic                    cb_rvalid,
  input logic                    cb_rerr,
  input logic [7:0]              cb_rdata,
  input logic                    sel_fire,
  input logic [31:0]             cur_off
);
  a_r10_split_answered: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |=> sp_rvalid);

  a_r10_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rvalid && sp_rerr) |-> (sp_rdata == '0));

  a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_rvalid && cb_rerr) |-> (cb_rdata == 8'h00));

  a_r9_combined_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && cb_ready) |=> cb_rvalid);

  a_r12_combined_yields: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |=> !cb_rvalid);

  a_r2_offset_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |=> (cur_off == 32'd0));

  a_r6_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cur_off <= 32'(ITEM_BYTES));
endmodule

bind cfgport_top cfgport_chk #(.DATA_BYTES(DATA_BYTES), .ITEM_BYTES(ITEM_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sp_valid(sp_valid), .cb_valid(cb_valid),
  .cb_ready(cb_ready), .sp_rvalid(sp_rvalid), .sp_rerr(sp_rerr),
  .sp_rdata(sp_rdata), .cb_rvalid(cb_rvalid), .cb_rerr(cb_rerr),
  .cb_rdata(cb_rdata), .sel_fire(sel_fire), .cur_off(cur_off)
);

// File: tb/cfgport_tb.sv
module cfgport_top_tb_top;
  localparam int DB    = 4;
  localparam int LIMIT = 8;
  localparam int IB    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        pl_valid = 0, pl_kind = 0, pl_table = 0;
  logic [13:0] pl_index = 0;
  logic [31:0] pl_field = 0;
  logic [7:0]  pl_byte = 0;
  logic        pl_ready;
  logic        sp_valid = 0, sp_reg = 0, sp_we = 0;
  logic [2:0]  sp_addr = 0;
  logic [3:0]  sp_size = 0;
  logic [15:0] sp_wdata = 0;
  logic        sp_ready, sp_rvalid, sp_rerr;
  logic [8*DB-1:0] sp_rdata;
  logic        cb_valid = 0, cb_we = 0;
  logic [3:0]  cb_size = 0;
  logic [15:0] cb_wdata = 0;
  logic        cb_ready, cb_rvalid, cb_rerr;
  logic [7:0]  cb_rdata;

  cfgport_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_kind(pl_kind), .pl_table(pl_table),
    .pl_index(pl_index), .pl_field(pl_field), .pl_byte(pl_byte),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_reg(sp_reg), .sp_we(sp_we),
    .sp_addr(sp_addr), .sp_size(sp_size), .sp_wdata(sp_wdata),
    .sp_rvalid(sp_rvalid), .sp_rerr(sp_rerr), .sp_rdata(sp_rdata),
    .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_we(cb_we), .cb_size(cb_size),
    .cb_wdata(cb_wdata), .cb_rvalid(cb_rvalid), .cb_rerr(cb_rerr), .cb_rdata(cb_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference: item tables plus a cursor
  int bm   [2][LIMIT][IB];
  int lenm [2][LIMIT];
  bit m_valid;
  int m_tbl, m_idx, m_off;

  function automatic void m_select(int key);
    int idx = key & 16'h3FFF;
    m_off = 0;
    if (idx < LIMIT) begin m_valid = 1; m_tbl = (key >> 15) & 1; m_idx = idx; end
    else m_valid = 0;
  endfunction

  function automatic logic [63:0] m_read(int n);
    logic [63:0] v = 0;
    int got = 0;
    if (m_valid && m_off < lenm[m_tbl][m_idx]) begin
      while (got < n && m_off < lenm[m_tbl][m_idx]) begin
        v = (v << 8) | 64'(bm[m_tbl][m_idx][m_off]);
        m_off++; got++;
      end
      v = v << (8 * (n - got));
    end
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock response presence check
  logic exp_sp_rv = 0, exp_cb_rv = 0;
  always @(posedge clk) begin
    exp_sp_rv <= rst_n && sp_valid;
    exp_cb_rv <= rst_n && cb_valid && !sp_valid;
  end
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (sp_rvalid !== exp_sp_rv || cb_rvalid !== exp_cb_rv) begin
      errors++;
      $display("FAIL R12 rvalid actual=%b%b expected=%b%b", sp_rvalid, cb_rvalid, exp_sp_rv, exp_cb_rv);
    end
  end

  task automatic preload(bit kind, bit tbl, int idx, int field, int b);
    @(negedge clk);
    pl_valid = 1; pl_kind = kind; pl_table = tbl; pl_index = 14'(idx);
    pl_field = 32'(field); pl_byte = 8'(b);
    @(posedge clk);
    @(negedge clk);
    pl_valid = 0;
    if (idx < LIMIT) begin
      if (kind) lenm[tbl][idx] = (field > IB) ? IB : field;
      else if (field < IB) bm[tbl][idx][field] = b;
    end
  endtask

  task automatic sp_op(string req, bit rg, bit we, int addr, int size, int wdata);
    bit ok;
    logic [63:0] exp = 0;
    if (!rg) begin
      ok = we && size == 2;
      if (ok) m_select(wdata);
    end else begin
      ok = addr == 0 && size >= 1 && size <= DB;
      if (ok && !we) exp = m_read(size);
    end
    @(negedge clk);
    sp_valid = 1; sp_reg = rg; sp_we = we; sp_addr = 3'(addr);
    sp_size = 4'(size); sp_wdata = 16'(wdata);
    @(posedge clk);
    @(negedge clk);
    sp_valid = 0;
    check({req, " err"}, 64'(sp_rerr), 64'(!ok));
    check({req, " data"}, 64'(sp_rdata), exp);
  endtask

  task automatic cb_op(string req, bit we, int size, int wdata);
    bit ok = 0;
    logic [63:0] exp = 0;
    if (size == 1) begin ok = 1; if (!we) exp = m_read(1); end
    else if (size == 2 && we) begin ok = 1; m_select(wdata); end
    @(negedge clk);
    cb_valid = 1; cb_we = we; cb_size = 4'(size); cb_wdata = 16'(wdata);
    @(posedge clk);
    @(negedge clk);
    cb_valid = 0;
    check({req, " err"}, 64'(cb_rerr), 64'(!ok));
    check({req, " data"}, 64'(cb_rdata), exp);
  endtask

  task automatic sel(string req, int key);
    sp_op(req, 0, 1, 0, 2, key);
  endtask

  task automatic rd(string req, int n);
    sp_op(req, 1, 0, 0, n, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) for (int i = 0; i < LIMIT; i++) begin
      lenm[t][i] = 0;
      for (int b = 0; b < IB; b++) bm[t][i][b] = 0;
    end
    m_valid = 1; m_tbl = 0; m_idx = 0; m_off = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 no response", 64'({sp_rvalid, cb_rvalid}), 64'(0));
    check("R1 preload ready", 64'(pl_ready), 64'(1));

    preload(1, 0, 0, 4, 0);
    preload(0, 0, 0, 0, 8'h43); preload(0, 0, 0, 1, 8'h46);
    preload(0, 0, 0, 2, 8'h47); preload(0, 0, 0, 3, 8'h30);
    preload(1, 0, 4, 10, 0);
    for (int b = 0; b < 10; b++) preload(0, 0, 4, b, 8'h10 + b);
    preload(1, 1, 4, 3, 0);
    preload(0, 1, 4, 0, 8'hA1); preload(0, 1, 4, 1, 8'hA2); preload(0, 1, 4, 2, 8'hA3);
    preload(1, 0, 7, 2, 0);
    preload(0, 0, 7, 0, 8'h77); preload(0, 0, 7, 1, 8'h78);
    // R11 out-of-range preloads dropped, length clamp
    preload(1, 0, 8, 5, 0);
    preload(0, 0, 4, 20, 8'hEE);
    preload(1, 1, 5, 40, 0);
    for (int b = 0; b < IB; b++) preload(0, 1, 5, b, 8'h50 + b);

    rd("R1 signature after reset", 4);
    rd("R7 read at end", 4);
    rd("R7 read at end again", 2);
    sel("R2 select", 4);
    rd("R5 two bytes", 2);
    sel("R2 reselect", 4);
    rd("R2 offset rewound", 1);
    rd("R5 four bytes", 4);
    rd("R5 next four", 4);
    rd("R6 partial padded", 4);
    rd("R7 past end", 4);
    sel("R4 table select", 16'h8004);
    rd("R4 second table", 4);
    sel("R4 bit14 ignored", 16'h4004);
    rd("R4 bit14 read", 2);
    sel("R3 at limit", 8);
    rd("R3 invalid reads zero", 4);
    rd("R7 invalid no advance", 1);
    sel("R3 limit minus one", 7);
    rd("R3 last valid item", 4);
    sel("R3 wide index", 16'h3FFF);
    rd("R3 wide invalid", 4);
    sel("R11 dropped index", 8);
    rd("R11 dropped index reads zero", 2);
    sel("R8 setup", 4);
    rd("R8 first", 1);
    sp_op("R8 split data write", 1, 1, 0, 1, 16'hFFFF);
    rd("R8 after split write", 1);
    cb_op("R8 combined write", 1, 1, 16'h00FF);
    cb_op("R8 after combined write", 0, 1, 0);
    cb_op("R9 combined select", 1, 2, 16'h0004);
    cb_op("R9 combined read", 0, 1, 0);
    cb_op("R9 size2 read rejected", 0, 2, 0);
    cb_op("R9 size4 write rejected", 1, 4, 16'h0007);
    cb_op("R9 after rejects", 0, 1, 0);
    sp_op("R10 ctl size1 rejected", 0, 1, 0, 1, 16'h0007);
    sp_op("R10 ctl read rejected", 0, 0, 0, 2, 0);
    sp_op("R10 data addr1 rejected", 1, 0, 1, 1, 0);
    sp_op("R10 data oversize rejected", 1, 0, 0, DB + 1, 0);
    rd("R10 after rejects", 2);
    sel("R11 clamp select", 16'h8005);
    rd("R11 clamp 0", 4); rd("R11 clamp 1", 4);
    rd("R11 clamp 2", 4); rd("R11 clamp 3", 4);
    rd("R11 clamp end", 4);

    // R11 preload stalls behind bus traffic
    sel("R11 stall setup", 4);
    @(negedge clk);
    pl_valid = 1; pl_kind = 0; pl_table = 0; pl_index = 14'd7; pl_field = 0; pl_byte = 8'hEE;
    sp_valid = 1; sp_reg = 1; sp_we = 0; sp_addr = 0; sp_size = 4'd1;
    #1 check("R11 pl_ready low", 64'(pl_ready), 64'(0));
    @(posedge clk);
    @(negedge clk);
    sp_valid = 0;
    check("R11 concurrent read", 64'(sp_rdata), m_read(1));
    #1 check("R11 pl_ready back", 64'(pl_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    pl_valid = 0;
    bm[0][7][0] = 8'hEE;
    sel("R11 stalled beat landed", 7);
    rd("R11 stalled beat landed", 2);

    // R12 both ports at once
    @(negedge clk);
    sp_valid = 1; sp_reg = 0; sp_we = 1; sp_size = 4'd2; sp_wdata = 16'h0004;
    cb_valid = 1; cb_we = 1; cb_size = 4'd2; cb_wdata = 16'h8004;
    m_select(16'h0004);
    #1 check("R12 cb_ready low", 64'(cb_ready), 64'(0));
    @(posedge clk);
    @(negedge clk);
    sp_valid = 0;
    check("R12 only split answered", 64'({sp_rvalid, cb_rvalid}), 64'(2'b10));
    @(posedge clk);
    @(negedge clk);
    cb_valid = 0;
    m_select(16'h8004);
    check("R12 combined taken later", 64'(cb_rvalid), 64'(1));
    rd("R12 combined select applied", 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule